// File: doc/BRIEF.md
# End-of-Write Status Poller

This block sits on the host side of a parallel byte-wide non-volatile memory. It issues the final write of a byte or page load. It then finds out when the memory has finished its internal programming by reading status bits from the data bus. This avoids waiting the worst-case programming time, which is about 5 ms. A request carries the last address and data byte. The block performs one write cycle and then one read cycle per clock to that address. It pulses `done_o` when the status pattern shows that programming has finished.

Two detection methods are available, and the mode is latched with the request. Complement polling compares the top data bit of each read against the top bit of the byte that was written: while programming runs the memory returns it inverted. Toggle polling watches the next bit down, which the memory flips on every read while it is busy. Completion is declared once two reads in a row agree on that bit. A cycle counter sized above the worst-case programming time ends a poll that never completes and pulses `err_o`. Bus timing is reduced to one access per clock, with read data valid in the cycle of the read strobe.

Top module: `eow_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `mem_we_o` and `mem_re_o` are all low.
- R2: A `req_i` sampled while `busy_o` is low is accepted. In the next cycle the block asserts `mem_we_o` for exactly one cycle with `mem_addr_o`/`mem_wdata_o` equal to the request's address and data. From the following cycle it asserts `mem_re_o` in every cycle at that same address until the poll ends.
- R3: A `req_i` sampled while `busy_o` is high is ignored: it causes no write, the captured address and data stay as they were, and the end of the running poll is not moved.
- R4: With mode 0 (complement polling), a read whose bit DW-1 equals bit DW-1 of the written byte completes the poll, and `done_o` is high in the cycle after that read.
- R5: With mode 1 (toggle polling), a read completes the poll only when its bit DW-2 equals bit DW-2 of the previous read of the same poll. The first read never completes the poll on its own. `done_o` is high in the cycle after the agreeing read.
- R6: Read bits DW-3..0 never affect the result. In mode 0, bit DW-2 is ignored, and in mode 1, bit DW-1 is ignored.
- R7: If TIMEOUT_CYC reads pass without completion, `err_o` is high for one cycle in the cycle after the last of those reads. A completion on that last read wins over the timeout.
- R8: `done_o` and `err_o` are single-cycle pulses that never occur together. `busy_o` is low in the cycle they are high, and a request in that cycle is accepted.
- R9: The mode is taken from `mode_i` at acceptance. Changes of `mode_i` during a poll have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request (one cycle) |
| mode_i | input | 1 | 0 = complement polling, 1 = toggle polling |
| addr_i | input | AW | Last written address |
| data_i | input | DW | Last written data byte |
| busy_o | output | 1 | Write or poll in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Timeout pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid with `mem_re_o` |

## Verification
The bench varies the memory's programming latency and the starting level of the toggle bit, and drives random values on the reserved bits throughout. In toggle mode the memory's final true bit can match the last busy value. A design that compared against the written byte, or that finished on the first read, would then report completion one cycle early or late. Latencies at and just beyond the timeout limit test the tie between a completion on the last read and the timeout, which an off-by-one counter would get wrong. A request issued mid-poll with the opposite mode and inverted address tests that neither a second write nor a changed address or mode leaks into the running poll.

// File: rtl/eow_pkg.sv
package eow_pkg;
  typedef enum logic {
    POLL_CMPL   = 1'b0,
    POLL_TOGGLE = 1'b1
  } poll_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_POLL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eow_timer.sv
module eow_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // fires on the LIMIT-th tick since clear
  assign expire_o = tick_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/eow_status_eval.sv
module eow_status_eval
  import eow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  poll_mode_e    mode_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic          fin_o
);
  localparam int CMPL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  logic have_prev_q;
  logic prev_tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_tgl_q  <= 1'b0;
    end else if (clear_i) begin
      have_prev_q <= 1'b0;
    end else if (sample_i) begin
      have_prev_q <= 1'b1;
      prev_tgl_q  <= rdata_i[TGL_BIT];
    end
  end

  logic cmpl_hit, tgl_hit;
  assign cmpl_hit = (rdata_i[CMPL_BIT] == wdata_i[CMPL_BIT]);
  assign tgl_hit  = have_prev_q && (rdata_i[TGL_BIT] == prev_tgl_q);

  always_comb begin
    fin_o = 1'b0;
    if (sample_i) begin
      unique case (mode_i)
        POLL_CMPL:   fin_o = cmpl_hit;
        POLL_TOGGLE: fin_o = tgl_hit;
        default:     fin_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eow_seq.sv
module eow_seq
  import eow_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          fin_i,
  input  logic          expire_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          clear_o,
  output logic          poll_o,
  output logic          wr_o,
  output poll_mode_e    mode_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  seq_state_e state_q, state_d;
  poll_mode_e mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic done_q, err_q, accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_POLL;
      ST_POLL:  if (fin_i || expire_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= POLL_CMPL;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q <= poll_mode_e'(mode_i);
        addr_q <= addr_i;
        data_q <= data_i;
      end
      done_q <= (state_q == ST_POLL) && fin_i;
      err_q  <= (state_q == ST_POLL) && !fin_i && expire_i;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign clear_o = (state_q == ST_WRITE);
  assign wr_o    = (state_q == ST_WRITE);
  assign poll_o  = (state_q == ST_POLL);
  assign mode_o  = mode_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/eow_poller.sv
module eow_poller
  import eow_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int CLK_MHZ     = 100,
  parameter int WC_MAX_US   = 5000,
  parameter int TIMEOUT_CYC = CLK_MHZ * WC_MAX_US * 5 / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic       fin, expire, clear, poll, wr;
  poll_mode_e mode_q;

  eow_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .mode_i   (mode_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .fin_i    (fin),
    .expire_i (expire),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .clear_o  (clear),
    .poll_o   (poll),
    .wr_o     (wr),
    .mode_o   (mode_q),
    .addr_o   (mem_addr_o),
    .data_o   (mem_wdata_o)
  );

  eow_status_eval #(.DW(DW)) u_eval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .sample_i (poll),
    .mode_i   (mode_q),
    .wdata_i  (mem_wdata_o),
    .rdata_i  (mem_rdata_i),
    .fin_o    (fin)
  );

  eow_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .tick_i   (poll),
    .expire_o (expire)
  );

  assign mem_we_o = wr;
  assign mem_re_o = poll;
endmodule

// File: rtl/eow_poller_chk.sv
module eow_poller_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          mode_q
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !busy_o && !mem_we_o && !mem_re_o); // R1
  AST_ACCEPT_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && req_i) |=> mem_we_o); // R2
  AST_WRITE_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o |=> mem_re_o && !mem_we_o); // R2
  AST_READ_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_re_o |-> $stable(mem_addr_o) && $stable(mem_wdata_o)); // R3
  AST_CMPL_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !mode_q && (mem_rdata_i[DW-1] == mem_wdata_o[DW-1])) |=> done_o); // R4
  AST_TGL_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && mode_q && !$past(mem_re_o)) |=> !done_o); // R5
  AST_TGL_DIFF_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && mode_q && $past(mem_re_o) && (mem_rdata_i[DW-2] != $past(mem_rdata_i[DW-2]))) |=> !done_o && mem_re_o || err_o); // R5
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(done_o && err_o)); // R8
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o || err_o) |-> !busy_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R8
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> !err_o); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(mem_we_o && mem_re_o)); // R2
endmodule

bind eow_poller eow_poller_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .mode_q      (mode_q)
);

// File: tb/eow_mem_model.sv
module eow_mem_model #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [15:0]   lat_i,
  input  logic          tog0_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d, junk;
  logic [15:0]   cnt;
  logic          tog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_a <= '0;
      last_d <= '0;
      cnt    <= '0;
      tog    <= 1'b0;
      junk   <= '0;
    end else begin
      junk <= DW'($urandom);
      if (we_i) begin
        last_a <= addr_i;
        last_d <= wdata_i;
        cnt    <= lat_i;
        tog    <= tog0_i;
      end else begin
        if (re_i && cnt != 0) tog <= ~tog;
        if (cnt != 0) cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    if (cnt != 0) begin
      rdata_o = junk;
      rdata_o[DW-1] = (addr_i == last_a) ? ~last_d[DW-1] : junk[DW-1];
      rdata_o[DW-2] = tog;
    end else if (addr_i == last_a) begin
      rdata_o = last_d;
    end else begin
      rdata_o = junk;
    end
  end
endmodule

// File: tb/eow_poller_tb_top.sv
module eow_poller_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int T_LIM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, done, err, we, re;
  logic [AW-1:0] maddr;
  logic [DW-1:0] wdata, rdata;
  logic [15:0] lat = '0;
  logic tog0 = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eow_poller #(.AW(AW), .DW(DW), .TIMEOUT_CYC(T_LIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .addr_i(addr), .data_i(data),
    .busy_o(busy), .done_o(done), .err_o(err), .mem_we_o(we), .mem_re_o(re),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  eow_mem_model #(.AW(AW), .DW(DW)) u_mem (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(maddr), .wdata_i(wdata),
    .lat_i(lat), .tog0_i(tog0), .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // cycle (counted from accept) in which done_o or err_o is seen
  function automatic int exp_end(input bit m, input int L, input bit t0, input bit d6, output bit is_err);
    int s;
    if (!m) s = L + 3;
    else if (L >= 1 && ((t0 ^ bit'((L - 1) & 1)) == d6)) s = L + 3;
    else s = L + 4;
    is_err = (s - 1 > T_LIM + 1);
    if (is_err) s = T_LIM + 2;
    return s;
  endfunction

  task automatic run(input bit m, input int L, input bit t0, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit poke);
    bit e_err, wr_ok, rd_ok, r3_ok;
    int s, seen;
    string rq;
    s = exp_end(m, L, t0, d[DW-2], e_err);
    wr_ok = 1'b1; rd_ok = 1'b1; r3_ok = 1'b1; seen = -1;
    req = 1'b1; mode = m; addr = a; data = d; lat = 16'(L); tog0 = t0;
    for (int n = 1; n <= s; n++) begin
      @(negedge clk);
      if (n == 1) req = 1'b0;
      if (poke && n == 2) begin req = 1'b1; mode = ~m; addr = ~a; data = ~d; end
      if (poke && n == 3) req = 1'b0;
      if (n == 1 && !(we && !re && maddr == a && wdata == d && busy)) wr_ok = 1'b0;
      if (n > 1 && n < s) begin
        if (!(re && !we && maddr == a && busy)) begin rd_ok = 1'b0; if (we) r3_ok = 1'b0; end
        if ((done || err) && seen < 0) seen = n;
      end
    end
    if (seen < 0) seen = s;
    rq = e_err ? "R7" : (m ? "R5 R6" : "R4 R6");
    if (poke) rq = {rq, " R3 R9"};
    check(wr_ok, "R2", "write cycle", int'(we), 1);
    check(rd_ok, "R2", "read cycles", int'(re), 1);
    check(seen == s && (e_err ? (err && !done) : (done && !err)), rq, "end cycle", seen, s);
    check(!busy, "R8", "busy at end", int'(busy), 0);
    if (poke) check(r3_ok, "R3", "no second write", 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !we && !re, "R1", "reset quiet", int'(busy) + int'(we) + int'(re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R1", "idle after reset", int'(busy), 0);
    // directed: complement mode
    run(1'b0, 0, 1'b0, 13'h0155, 8'h3c, 1'b0);           // R4
    run(1'b0, 5, 1'b1, 13'h1abc, 8'hc3, 1'b0);           // R4 R6
    run(1'b0, T_LIM - 1, 1'b0, 13'h0001, 8'h80, 1'b0);   // R7 completion wins
    run(1'b0, T_LIM, 1'b0, 13'h0002, 8'h7f, 1'b0);       // R7 timeout
    // directed: toggle mode
    run(1'b1, 0, 1'b0, 13'h0aaa, 8'h40, 1'b0);           // R5 first read alone
    run(1'b1, 1, 1'b1, 13'h0aab, 8'h40, 1'b0);           // R5 end value matches
    run(1'b1, 1, 1'b0, 13'h0aac, 8'h40, 1'b0);           // R5 end value differs
    run(1'b1, T_LIM - 2, 1'b1, 13'h0100, 8'h00, 1'b0);   // R7 edge
    run(1'b1, T_LIM - 1, 1'b1, 13'h0101, 8'h00, 1'b0);   // R7 edge
    run(1'b1, T_LIM - 1, 1'b0, 13'h0102, 8'h00, 1'b0);   // R7 edge
    // mid-poll request with flipped mode
    run(1'b0, 6, 1'b0, 13'h0777, 8'h55, 1'b1);           // R3 R9
    run(1'b1, 6, 1'b1, 13'h0778, 8'hb9, 1'b1);           // R3 R9
    // random mix
    for (int i = 0; i < 60; i++) begin
      run(1'($urandom), int'($urandom % (T_LIM + 4)), 1'($urandom),
          AW'($urandom), DW'($urandom), ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule